// File: doc/BRIEF.md
# SCSI Target Byte Handshake Engine

This block performs the target side of the SCSI asynchronous REQ/ACK byte handshake, one handshake per byte, in either direction. A transfer is launched with a single-cycle start pulse that carries a direction and a byte count. Bytes going to the host are pulled from an internal valid/ready port, placed on the bus data lines with a generated parity bit, and offered with REQ. Bytes coming from the host are requested with REQ, sampled after a settle window, parity-checked, and handed out on a second valid/ready port.

ACK comes in through a multi-flop synchroniser. A latched assertion-edge capture, cleared just before each REQ, lets the engine react to an ACK that was only briefly active. Both the data-setup window and the sample window are a fixed delay given in nanoseconds and converted to clock cycles from the clock frequency parameter. A bus-reset input ends every wait at once and returns the engine to idle with the bus released.

All bus signals are active-high at the ports. A logic 1 on `req_o`, `ack_i` or `db_oe_o` means asserted or driven. Any inversion for the physical bus lies outside the block.

Top module: `scsi_hs_engine`

## Requirements
- R1: When sending, `db_oe_o` is high with a constant `db_o`/`dbp_o` for exactly DLY cycles before `req_o` rises, where DLY = ceil(DELAY_NS × CLK_MHZ / 1000), minimum 1. The byte and parity stay constant while driven.
- R2: When sending, `dbp_o` is odd parity: the XOR of the 8 data bits and `dbp_o` is 1.
- R3: An ACK that is asserted for only one clock cycle while REQ is high still completes the handshake, in both directions.
- R4: When sending, `req_o` and `db_oe_o` fall in the same cycle after ACK is seen. The next byte is not accepted (`in_ready_o`) until ACK has been seen deasserted.
- R5: When receiving, `req_o` stays high for exactly DLY+2 cycles after the cycle in which `ack_i` rises: 2 synchroniser cycles plus DLY sample cycles. The byte on `db_i` is delivered unchanged on `out_data_o`.
- R6: When receiving, `req_o` is not raised again for the next byte until the host has released ACK.
- R7: A received byte whose 8 data bits XOR `dbp_i` equal 0 sets `par_err_o`. The flag stays set until the next accepted start, which clears it.
- R8: `bus_rst_i` forces the engine idle on the next cycle, with `req_o`, `db_oe_o` and `busy_o` low and no `done_o`.
- R9: `done_o` is a one-cycle pulse after the last byte's ACK release (receive: after the last byte is taken). A start with count 0 gives `done_o` in the following cycle, with no REQ.
- R10: `out_valid_o` and `out_data_o` hold steady until `out_ready_i` is high.
- R11: `start_i` is acted on only while idle. `dir_tx_i`=1 selects sending and 0 selects receiving. `count_i` is the number of bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a transfer (taken when idle) |
| dir_tx_i | input | 1 | 1 = bytes to host, 0 = bytes from host |
| count_i | input | CNT_W | Number of bytes in the transfer |
| bus_rst_i | input | 1 | Bus reset: abort and release |
| busy_o | output | 1 | Engine not idle |
| done_o | output | 1 | One-cycle completion pulse |
| par_err_o | output | 1 | Sticky received-parity error |
| in_valid_i | input | 1 | Byte available to send |
| in_data_i | input | 8 | Byte to send |
| in_ready_o | output | 1 | Engine takes the byte to send |
| out_valid_o | output | 1 | Received byte available |
| out_data_o | output | 8 | Received byte |
| out_ready_i | input | 1 | Consumer takes received byte |
| db_o | output | 8 | Bus data driven to host |
| dbp_o | output | 1 | Bus parity driven to host |
| db_oe_o | output | 1 | Data/parity drive enable |
| db_i | input | 8 | Bus data from host |
| dbp_i | input | 1 | Bus parity from host |
| req_o | output | 1 | REQ asserted |
| ack_i | input | 1 | ACK from host (asynchronous) |

## Verification
The bench builds the engine with CLK_MHZ=250 and DELAY_NS=20, which gives a 5-cycle setup and sample window, and keeps CNT_W=8 and two synchroniser stages. The short window lets many multi-byte transfers in both directions fit in a short run. It also keeps the exact REQ timing of R1 and R5 easy to count against the bench's own formula. The behavioural host can answer with one-cycle ACK pulses, inject a parity fault on a chosen byte, stall the receive port, or never answer. This reaches the short-pulse path, the sticky flag and its clearing, output holding, and bus-reset abort.

// File: rtl/scsi_hs_pkg.sv
package scsi_hs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TX_FETCH,
    ST_TX_SETUP,
    ST_TX_WAIT_ACK,
    ST_TX_WAIT_REL,
    ST_RX_WAIT_ACK,
    ST_RX_SAMPLE,
    ST_RX_WAIT_REL,
    ST_RX_PUSH,
    ST_DONE
  } hs_state_e;

  // Odd parity bit for a data byte: total number of ones becomes odd.
  function automatic logic odd_parity(input logic [7:0] d);
    return ~(^d);
  endfunction

  // Nanosecond window converted to whole clock cycles, rounded up, at least 1.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  logic clr_i,
  output logic lvl_o,
  output logic edge_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              cap_q;
  logic              cap_d;
  logic              rise;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= ack_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign lvl_o = chain_q[STAGES-1];
  assign rise  = lvl_o & ~prev_q;

  // A fresh assertion edge wins over a clear in the same cycle.
  always_comb begin
    cap_d = cap_q;
    if (clr_i) cap_d = 1'b0;
    if (rise)  cap_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      prev_q <= lvl_o;
      cap_q  <= cap_d;
    end
  end

  assign edge_o = cap_q | rise;

endmodule

// File: rtl/hs_delay_timer.sv
module hs_delay_timer #(
  parameter int unsigned CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  localparam int unsigned W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = W'(CYCLES - 1);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/hs_rx_capture.sv
module hs_rx_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_i,
  input  logic       clr_err_i,
  input  logic [7:0] db_i,
  input  logic       dbp_i,
  output logic [7:0] data_o,
  output logic       err_o
);

  logic [7:0] data_q;
  logic       err_q;
  logic       err_d;
  logic       bad;

  assign bad = cap_i & ~(^{db_i, dbp_i});

  always_comb begin
    err_d = err_q;
    if (clr_err_i) err_d = 1'b0;
    else if (bad)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (cap_i) data_q <= db_i;
      err_q <= err_d;
    end
  end

  assign data_o = data_q;
  assign err_o  = err_q;

endmodule

// File: rtl/scsi_hs_engine.sv
module scsi_hs_engine
  import scsi_hs_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned DELAY_NS    = 100,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_tx_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             bus_rst_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             par_err_o,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  input  logic             out_ready_i,
  output logic [7:0]       db_o,
  output logic             dbp_o,
  output logic             db_oe_o,
  input  logic [7:0]       db_i,
  input  logic             dbp_i,
  output logic             req_o,
  input  logic             ack_i
);

  localparam int unsigned DLY = ns_to_cycles(DELAY_NS, CLK_MHZ);

  hs_state_e        st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [7:0]       txd_q, txd_d;
  logic             txp_q, txp_d;

  logic ack_lvl, ack_edge, ack_seen;
  logic edge_clr, tmr_load, tmr_exp, rx_cap, err_clr;

  hs_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack_i  (ack_i),
    .clr_i  (edge_clr),
    .lvl_o  (ack_lvl),
    .edge_o (ack_edge)
  );

  hs_delay_timer #(.CYCLES(DLY)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .expired_o (tmr_exp)
  );

  hs_rx_capture u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (rx_cap),
    .clr_err_i (err_clr),
    .db_i      (db_i),
    .dbp_i     (dbp_i),
    .data_o    (out_data_o),
    .err_o     (par_err_o)
  );

  assign ack_seen = ack_lvl | ack_edge;

  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    txd_d    = txd_q;
    txp_d    = txp_q;
    edge_clr = 1'b0;
    tmr_load = 1'b0;
    rx_cap   = 1'b0;
    err_clr  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          err_clr = 1'b1;
          rem_d   = count_i;
          if (count_i == '0) begin
            st_d = ST_DONE;
          end else if (dir_tx_i) begin
            st_d = ST_TX_FETCH;
          end else begin
            edge_clr = 1'b1;
            st_d     = ST_RX_WAIT_ACK;
          end
        end
      end
      ST_TX_FETCH: begin
        if (in_valid_i) begin
          txd_d    = in_data_i;
          txp_d    = odd_parity(in_data_i);
          tmr_load = 1'b1;
          st_d     = ST_TX_SETUP;
        end
      end
      ST_TX_SETUP: begin
        if (tmr_exp) begin
          edge_clr = 1'b1;
          st_d     = ST_TX_WAIT_ACK;
        end
      end
      ST_TX_WAIT_ACK: begin
        if (ack_seen) begin
          rem_d = rem_q - 1'b1;
          st_d  = ST_TX_WAIT_REL;
        end
      end
      ST_TX_WAIT_REL: begin
        if (!ack_lvl) st_d = (rem_q == '0) ? ST_DONE : ST_TX_FETCH;
      end
      ST_RX_WAIT_ACK: begin
        if (ack_seen) begin
          tmr_load = 1'b1;
          st_d     = ST_RX_SAMPLE;
        end
      end
      ST_RX_SAMPLE: begin
        if (tmr_exp) begin
          rx_cap = 1'b1;
          rem_d  = rem_q - 1'b1;
          st_d   = ST_RX_WAIT_REL;
        end
      end
      ST_RX_WAIT_REL: begin
        if (!ack_lvl) st_d = ST_RX_PUSH;
      end
      ST_RX_PUSH: begin
        if (out_ready_i) begin
          if (rem_q == '0) begin
            st_d = ST_DONE;
          end else begin
            edge_clr = 1'b1;
            st_d     = ST_RX_WAIT_ACK;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (bus_rst_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      txd_q <= '0;
      txp_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      txd_q <= txd_d;
      txp_q <= txp_d;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign in_ready_o  = (st_q == ST_TX_FETCH);
  assign out_valid_o = (st_q == ST_RX_PUSH);
  assign db_oe_o     = (st_q == ST_TX_SETUP) || (st_q == ST_TX_WAIT_ACK);
  assign db_o        = txd_q;
  assign dbp_o       = txp_q;
  assign req_o       = (st_q == ST_TX_WAIT_ACK) || (st_q == ST_RX_WAIT_ACK) ||
                       (st_q == ST_RX_SAMPLE);

endmodule

// File: rtl/scsi_hs_engine_chk.sv
module scsi_hs_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       bus_rst_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       par_err_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic [7:0] db_o,
  input logic       dbp_o,
  input logic       db_oe_o,
  input logic       req_o
);

  AST_TX_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (db_oe_o && $past(db_oe_o)) |-> ($stable(db_o) && $stable(dbp_o))); // R1

  AST_REQ_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_o) && db_oe_o) |-> $past(db_oe_o)); // R1

  AST_TX_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe_o |-> (^{db_o, dbp_o})); // R2

  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(db_oe_o) |-> !req_o); // R4

  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_o && !start_i) |=> par_err_o); // R7

  AST_BUS_RST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> (!busy_o && !req_o && !db_oe_o && !done_o)); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !bus_rst_i) |=>
      (out_valid_o && $stable(out_data_o))); // R10

endmodule

bind scsi_hs_engine scsi_hs_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .bus_rst_i   (bus_rst_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .par_err_o   (par_err_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .db_o        (db_o),
  .dbp_o       (dbp_o),
  .db_oe_o     (db_oe_o),
  .req_o       (req_o)
);

// File: tb/scsi_hs_engine_bench.sv
`timescale 1ns/1ps
module scsi_hs_engine_bench;

  localparam int CLK_MHZ = 250;
  localparam int DELAY_NS = 20;
  localparam int EXP_DLY = (DELAY_NS * CLK_MHZ + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, dir_tx_i = 1'b0, bus_rst_i = 1'b0;
  logic [7:0] count_i = '0;
  logic       busy_o, done_o, par_err_o;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_ready_o, out_valid_o;
  logic [7:0] out_data_o;
  logic       out_ready_i = 1'b1;
  logic [7:0] db_o;
  logic       dbp_o, db_oe_o;
  logic [7:0] db_i = '0;
  logic       dbp_i = 1'b1;
  logic       req_o;
  logic       ack_i = 1'b0;

  always #2 clk = ~clk;

  scsi_hs_engine #(.CLK_MHZ(CLK_MHZ), .DELAY_NS(DELAY_NS), .CNT_W(8), .SYNC_STAGES(2))
  u_scsi_hs_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_tx_i(dir_tx_i),
    .count_i(count_i), .bus_rst_i(bus_rst_i), .busy_o(busy_o), .done_o(done_o),
    .par_err_o(par_err_o), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_ready_i(out_ready_i), .db_o(db_o), .dbp_o(dbp_o), .db_oe_o(db_oe_o),
    .db_i(db_i), .dbp_i(dbp_i), .req_o(req_o), .ack_i(ack_i)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // host / source / sink state
  logic [7:0] tx_q[$];
  logic [7:0] tx_exp[$];
  logic [7:0] rx_src[$];
  logic [7:0] rx_exp[$];
  bit  cur_tx = 0, h_short = 0, h_stall = 0, h_noack = 0;
  int  h_bad = -1, h_dly = 2, rx_idx = 0, wcnt = 0;
  bit  ack_drv = 0, served = 0, xfer_pend = 0;
  bit  rx_track = 0;
  int  rx_cnt = 0, oe_run = 0, done_cnt = 0;
  bit  p_req = 0, p_oe = 0, p_ov = 0, p_or = 0, p_brst = 0;
  logic [7:0] p_db = '0, p_od = '0;
  logic       p_dbp = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (rst_n) begin
      // ---- monitors ----
      if (done_o) done_cnt++;
      oe_run = db_oe_o ? oe_run + 1 : 0;
      if (req_o && !p_req && db_oe_o) begin
        logic [7:0] e;
        e = (tx_exp.size() > 0) ? tx_exp.pop_front() : 8'hxx;
        check(oe_run - 1 == EXP_DLY, "R1 setup cycles", oe_run - 1, EXP_DLY);
        check(db_o == e, "R1 tx byte", db_o, e);
        check((^{db_o, dbp_o}) == 1'b1, "R2 odd parity", dbp_o, ~(^db_o));
      end
      if (db_oe_o && p_oe)
        check(db_o == p_db && dbp_o == p_dbp, "R1 byte stable", db_o, p_db);
      if (p_req && p_oe && !p_brst)
        check(req_o == db_oe_o, "R4 release together", req_o, db_oe_o);
      if (in_ready_o)
        check(!ack_drv, "R4 next byte after ack release", ack_drv, 0);
      if (req_o && !p_req && !db_oe_o)
        check(!ack_drv, "R6 req after ack release", ack_drv, 0);
      if (rx_track) begin
        if (req_o) rx_cnt++;
        else begin
          check(rx_cnt == EXP_DLY + 2, "R5 sample window", rx_cnt, EXP_DLY + 2);
          rx_track = 0;
        end
      end
      if (p_ov && !p_or && !p_brst)
        check(out_valid_o && out_data_o == p_od, "R10 hold", out_data_o, p_od);
      p_req = req_o; p_oe = db_oe_o; p_db = db_o; p_dbp = dbp_o;
      p_ov = out_valid_o; p_od = out_data_o; p_brst = bus_rst_i;

      // ---- receive sink ----
      out_ready_i = h_stall ? (cyc % 3 == 0) : 1'b1;
      p_or = out_ready_i;
      if (out_valid_o && out_ready_i) begin
        logic [7:0] e;
        e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 8'hxx;
        check(out_data_o == e, "R5 rx byte", out_data_o, e);
      end

      // ---- send source ----
      if (xfer_pend && tx_q.size() > 0) void'(tx_q.pop_front());
      in_valid_i = (tx_q.size() > 0);
      in_data_i  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
      xfer_pend  = in_valid_i && in_ready_o;

      // ---- host responder ----
      if (!req_o) served = 0;
      if (ack_drv) begin
        if (h_short || !req_o) ack_drv = 0;
      end else if (req_o && !served && !h_noack) begin
        wcnt++;
        if (wcnt >= h_dly) begin
          ack_drv = 1; served = 1; wcnt = 0;
          if (!cur_tx) begin
            logic [7:0] b;
            b = (rx_src.size() > 0) ? rx_src.pop_front() : 8'h00;
            db_i  = b;
            dbp_i = (rx_idx == h_bad) ? (^b) : ~(^b);
            rx_exp.push_back(b);
            rx_idx++;
            rx_track = 1; rx_cnt = 0;
          end
        end
      end
      ack_i = ack_drv;
    end
  end

  function automatic logic [7:0] pat(input int i, input int seed);
    if (i == 0) return 8'h00;
    if (i == 1) return 8'hFF;
    return 8'((i * 73 + seed * 5 + 11) & 255);
  endfunction

  task automatic run(input bit tx, input int n, input int bad, input bit shortp,
                     input bit stall, input int seed, input string tag);
    int dn;
    bit got;
    cur_tx = tx; h_short = shortp; h_stall = stall; h_bad = bad; rx_idx = 0;
    for (int i = 0; i < n; i++) begin
      if (tx) begin tx_q.push_back(pat(i, seed)); tx_exp.push_back(pat(i, seed)); end
      else rx_src.push_back(pat(i, seed));
    end
    @(negedge clk);
    dir_tx_i = tx; count_i = 8'(n); start_i = 1'b1; done_cnt = 0;
    @(negedge clk);
    start_i = 1'b0;
    got = 0;
    for (int k = 0; k < 4000 && !got; k++) begin
      @(negedge clk);
      if (done_cnt > 0) got = 1;
    end
    repeat (3) @(negedge clk);
    dn = done_cnt;
    check(dn == 1, {"R9 done once ", tag}, dn, 1);
    check(tx_exp.size() == 0 && rx_exp.size() == 0 && rx_src.size() == 0,
          {"R11 all bytes moved ", tag}, tx_exp.size() + rx_exp.size(), 0);
    check(par_err_o == (bad >= 0), {"R7 parity flag ", tag}, par_err_o, bad >= 0);
    check(!busy_o, {"R9 idle after done ", tag}, busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!req_o && !db_oe_o && !busy_o && !done_o && !par_err_o, "R8 reset state",
          {req_o, db_oe_o, busy_o, done_o, par_err_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!req_o && !db_oe_o && !busy_o && !in_ready_o && !out_valid_o,
          "R11 idle without start", {req_o, db_oe_o, busy_o}, 0);

    run(1, 4, -1, 0, 0, 1, "tx4");              // R1 R2 R4
    run(1, 3, -1, 1, 0, 2, "tx short ack");     // R3
    run(0, 4, -1, 0, 0, 3, "rx4");              // R5 R6
    run(0, 5, -1, 0, 1, 4, "rx stall");         // R10
    run(0, 3, -1, 1, 0, 5, "rx short ack");     // R3
    run(0, 4, 2, 0, 0, 6, "rx bad parity");     // R7

    // R7: a new start clears the sticky flag
    @(negedge clk);
    dir_tx_i = 1'b0; count_i = 8'd0; start_i = 1'b1; done_cnt = 0;
    @(negedge clk);
    start_i = 1'b0;
    check(!par_err_o, "R7 cleared by start", par_err_o, 0);
    // R9: zero count gives done in the following cycle, no REQ
    check(done_o && !req_o, "R9 zero count done", done_o, 1);
    @(negedge clk);
    check(!done_o && !busy_o, "R9 done single cycle", done_o, 0);

    // R8: bus reset while REQ waits for an ACK that never comes
    h_noack = 1; cur_tx = 1;
    tx_q.push_back(8'h5A); tx_q.push_back(8'h33);
    tx_exp.push_back(8'h5A);
    @(negedge clk);
    dir_tx_i = 1'b1; count_i = 8'd2; start_i = 1'b1; done_cnt = 0;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 50 && !req_o; k++) @(negedge clk);
    check(req_o && db_oe_o, "R1 req raised before abort", req_o, 1);
    repeat (4) @(negedge clk);
    bus_rst_i = 1'b1;
    @(negedge clk);
    bus_rst_i = 1'b0;
    check(!req_o && !db_oe_o && !busy_o, "R8 abort releases bus",
          {req_o, db_oe_o, busy_o}, 0);
    repeat (10) @(negedge clk);
    check(done_cnt == 0, "R8 no done after abort", done_cnt, 0);
    tx_q.delete(); tx_exp.delete(); h_noack = 0;
    repeat (3) @(negedge clk);

    run(1, 6, -1, 0, 0, 7, "tx after abort");   // R8 recovery, R1

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule